// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Mode Decoder and Identifier Readout

This block is a synthesizable behavioural model of a byte-wide one-time-programmable memory together with the logic that turns its control lines into an operating mode. Voltage levels are not modelled. The combined output-enable/supply line arrives as a two-bit level code. A separate flag marks a high voltage on address bit 9. Every clock, a small state machine samples the chip enable, the level code, the flag and the address, and settles into one of six modes. The next cycle the outputs reflect that mode. The outputs are a data byte plus a separate drive enable, which stands in for the bus being driven or left floating.

The array powers up and resets to all ones. A program pulse is a falling edge of chip enable while the supply line is at program level. It can only clear bits: the addressed byte becomes its old value AND the data input. Holding the high-voltage flag while both enables are low, with every other address bit low, replaces the array with two fixed identifier bytes. Each identifier byte carries odd parity in its top bit.

The states are `M_STANDBY`, `M_READ`, `M_OFF`, `M_PROG`, `M_INHIBIT` and `M_IDENT`. Every state can move to every other state on any clock, and the sampled inputs alone choose the next state:
- chip enable high and level code program gives `M_INHIBIT`.
- chip enable high with any other level code gives `M_STANDBY`.
- chip enable low and level code program gives `M_PROG`.
- chip enable low and level code low, with the identifier condition met, gives `M_IDENT`.
- chip enable low and level code low otherwise gives `M_READ`.
- chip enable low and level code high or the unused code 3 gives `M_OFF`.

Reset forces `M_STANDBY`.

Top module: `otp_mem_decoder`

## Requirements
- R1: During and after reset, the state is standby. Every stored byte reads back as FFh until it is programmed.
- R2: With chip enable low and level code 2'b00 (low) sampled on a clock edge, `dq_oe` is 1 after that edge. `dq_out` then carries the byte stored at the sampled address.
- R3: With chip enable high and the level code not 2'b10, `dq_oe` is 0 after the edge, whatever the other inputs are.
- R4: With chip enable low and level code 2'b01 (high) or 2'b11 (treated as high), `dq_oe` is 0 after the edge.
- R5: A clock edge that sees chip enable low with level code 2'b10 (program) counts as a program pulse only if chip enable was high at the previous edge. The pulse sets the addressed byte to old AND `din`, so bits are only ever cleared. `dq_oe` is 0 in program mode, and holding chip enable low causes no second pulse.
- R6: With chip enable high and level code 2'b10, nothing is written and `dq_oe` is 0.
- R7: A read after programming (both enables low) returns the byte as changed by the program pulses.
- R8: With both enables low and `a9_hv` set, and with every address bit other than bits 0 and 9 low, the output is C2h when address bit 0 is 0 and 91h when address bit 0 is 1.
- R9: Each identifier byte has an odd count of ones, and bit 7 is the parity bit.
- R10: When `a9_hv` is set but some address bit other than bits 0 and 9 is high, the output is the array byte instead of an identifier.
- R11: The storage holds 2**STORE_W bytes (default 1024). It is indexed by the low STORE_W address bits, so addresses that differ only above those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; refills the array with ones |
| ce_n | input | 1 | Chip enable, active low; its falling edge is the program pulse |
| oe_lvl | input | 2 | Output-enable/supply level: 00 low, 01 high, 10 program, 11 as high |
| a9_hv | input | 1 | High-voltage flag on address bit 9 |
| addr | input | 16 | Byte address |
| din | input | 8 | Data to program |
| dq_out | output | 8 | Data driven toward the bus |
| dq_oe | output | 1 | 1 when the bus is driven, 0 when it floats |

## Verification
The hardest case to reach is the identifier guard. `a9_hv` must be high with both enables low, and every address bit except 0 and 9 must be low. The nearby failing cases also matter: a single stray high bit must fall back to the array. The stimulus draws most addresses from a short list that includes 0000h, 0001h, 0200h, 0201h and near misses such as 0202h and 8001h. Random programming runs use the same list, so identifier, fallback and aliased array reads hit bytes that have already been cleared. The falling-edge rule gets its own sequences, in which chip enable stays low across several program-level cycles with new data.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_PROG = 2'b10,
        LVL_ALT  = 2'b11
    } lvl_t;

    typedef enum logic [2:0] {
        M_STANDBY = 3'd0,
        M_READ    = 3'd1,
        M_OFF     = 3'd2,
        M_PROG    = 3'd3,
        M_INHIBIT = 3'd4,
        M_IDENT   = 3'd5
    } mode_t;

endpackage

// File: rtl/otp_mode_fsm.sv
module otp_mode_fsm
    import otp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic [1:0] oe_lvl,
    input  logic       a9_hv,
    input  logic       id_addr_ok,
    output logic       wr_en,
    output logic       drive,
    output logic       use_id
);

    mode_t state_q;
    mode_t state_d;
    logic  ce_n_q;

    // next-state decode from the sampled control lines
    always_comb begin
        state_d = M_STANDBY;
        if (ce_n) begin
            state_d = (oe_lvl == LVL_PROG) ? M_INHIBIT : M_STANDBY;
        end else begin
            unique case (oe_lvl)
                LVL_PROG: state_d = M_PROG;
                LVL_LOW:  state_d = (a9_hv && id_addr_ok) ? M_IDENT : M_READ;
                LVL_HIGH,
                LVL_ALT:  state_d = M_OFF;
                default:  state_d = M_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= M_STANDBY;
            ce_n_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            ce_n_q  <= ce_n;
        end
    end

    // outputs
    always_comb begin
        wr_en  = ce_n_q && !ce_n && (oe_lvl == LVL_PROG);
        drive  = 1'b0;
        use_id = 1'b0;
        unique case (state_q)
            M_READ:  drive = 1'b1;
            M_IDENT: begin
                drive  = 1'b1;
                use_id = 1'b1;
            end
            M_STANDBY, M_OFF, M_PROG, M_INHIBIT: drive = 1'b0;
            default: drive = 1'b0;
        endcase
    end

    // one pulse per falling edge of chip enable
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // a high chip enable never writes
    assert_inhibit_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !wr_en);

endmodule

// File: rtl/otp_array.sv
module otp_array #(
    parameter int STORE_W = 10,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [STORE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]  wr_mask,
    input  logic [STORE_W-1:0] rd_idx,
    output logic [DATA_W-1:0]  rd_data
);

    localparam int DEPTH = 1 << STORE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] old_byte;

    assign old_byte = mem[wr_idx];
    assign rd_data  = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= old_byte & wr_mask;
        end
    end

    // a program pulse never raises a bit
    assert_clear_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem[$past(wr_idx)] & ~$past(old_byte)) == '0));

endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom #(
    parameter logic [7:0] MFR_BYTE = 8'hC2,
    parameter logic [7:0] DEV_BYTE = 8'h91,
    parameter bit         GEN_PARITY = 1'b1
) (
    input  logic       sel_dev,
    output logic [7:0] id_byte
);

    logic [6:0] low7;
    assign low7 = sel_dev ? DEV_BYTE[6:0] : MFR_BYTE[6:0];

    generate
        if (GEN_PARITY) begin : g_par
            assign id_byte = {~(^low7), low7};
        end else begin : g_raw
            assign id_byte = sel_dev ? DEV_BYTE : MFR_BYTE;
        end
    endgenerate

    // identifier bytes always carry odd parity
    always_comb begin
        assert_odd_parity_R9: assert ((^id_byte) == 1'b1);
    end

endmodule

// File: rtl/otp_mem_decoder.sv
module otp_mem_decoder
    import otp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int STORE_W = 10,
    parameter int HV_BIT  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [1:0]        oe_lvl,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    localparam logic [ADDR_W-1:0] ID_FREE =
        (ADDR_W'(1) << HV_BIT) | ADDR_W'(1);

    logic               wr_en;
    logic               drive;
    logic               use_id;
    logic               id_addr_ok;
    logic [STORE_W-1:0] idx_q;
    logic               a0_q;
    logic [DATA_W-1:0]  arr_byte;
    logic [7:0]         id_byte;

    assign id_addr_ok = ((addr & ~ID_FREE) == '0);

    otp_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .oe_lvl     (oe_lvl),
        .a9_hv      (a9_hv),
        .id_addr_ok (id_addr_ok),
        .wr_en      (wr_en),
        .drive      (drive),
        .use_id     (use_id)
    );

    otp_array #(.STORE_W(STORE_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (addr[STORE_W-1:0]),
        .wr_mask (din),
        .rd_idx  (idx_q),
        .rd_data (arr_byte)
    );

    otp_id_rom u_id (
        .sel_dev (a0_q),
        .id_byte (id_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            a0_q  <= 1'b0;
        end else begin
            idx_q <= addr[STORE_W-1:0];
            a0_q  <= addr[0];
        end
    end

    assign dq_oe  = drive;
    assign dq_out = use_id ? DATA_W'(id_byte) : arr_byte;

    assert_standby_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n) |-> !dq_oe);

    assert_disable_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ce_n) && $past(oe_lvl) inside {2'b01, 2'b11}) |-> !dq_oe);

    assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ce_n) && $past(oe_lvl) == 2'b00) |-> dq_oe);

    assert_prog_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(oe_lvl) == 2'b10) |-> !dq_oe);

endmodule

// File: tb/otp_mem_decoder_bench.sv
module otp_mem_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic [1:0]  oe_lvl = 2'b01;
    logic        a9_hv = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    otp_mem_decoder u_otp_mem_decoder (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_lvl(oe_lvl),
        .a9_hv(a9_hv), .addr(addr), .din(din),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // behavioural reference
    logic [7:0] ref_mem [0:1023];
    logic       ref_prev_ce;
    logic       exp_oe;
    logic [7:0] exp_dat;
    string      exp_tag;
    logic       model_ok = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) ref_mem[i] = 8'hFF;
            ref_prev_ce = 1'b1;
            exp_oe  = 1'b0;
            exp_dat = 8'hFF;
            exp_tag = "R1";
            model_ok = 1'b1;
        end else begin
            automatic int  ix = int'(addr) % 1024;
            automatic bit  id_ok = a9_hv && ((addr & 16'hFDFE) == 16'h0000);
            if (ref_prev_ce && !ce_n && oe_lvl == 2'b10)
                ref_mem[ix] = ref_mem[ix] & din;
            ref_prev_ce = ce_n;
            exp_oe = !ce_n && (oe_lvl == 2'b00);
            exp_dat = id_ok ? (addr[0] ? 8'h91 : 8'hC2) : ref_mem[ix];
            if (ce_n)                 exp_tag = (oe_lvl == 2'b10) ? "R6" : "R3";
            else if (oe_lvl == 2'b10) exp_tag = "R5";
            else if (oe_lvl != 2'b00) exp_tag = "R4";
            else if (id_ok)           exp_tag = "R8";
            else if (a9_hv)           exp_tag = "R10";
            else                      exp_tag = (addr > 16'd1023) ? "R11" : "R2";
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (model_ok) begin
            chk(dq_oe == exp_oe, exp_tag, dq_oe, exp_oe);
            if (exp_oe) chk(dq_out == exp_dat, exp_tag, dq_out, exp_dat);
        end
    end

    task automatic drive(input logic c, input logic [1:0] l, input logic hv,
                         input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = c; oe_lvl = l; a9_hv = hv; addr = a; din = d;
    endtask

    // one read; returns the byte seen on the following negedge
    task automatic rd(input logic hv, input logic [15:0] a, output logic [7:0] v, output logic oe);
        drive(1'b0, 2'b00, hv, a, 8'h00);
        @(negedge clk);
        #1;
        v = dq_out; oe = dq_oe;
    endtask

    task automatic pulse(input logic [15:0] a, input logic [7:0] d);
        drive(1'b1, 2'b10, 1'b0, a, d);
        drive(1'b0, 2'b10, 1'b0, a, d);
        drive(1'b1, 2'b10, 1'b0, a, d);
    endtask

    logic [7:0] v;
    logic       oe;

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(dq_oe == 1'b0, "R1", dq_oe, 0);
        rst_n = 1'b1;

        rd(1'b0, 16'd5, v, oe);      chk(v == 8'hFF && oe, "R1", v, 8'hFF);
        rd(1'b0, 16'd1023, v, oe);   chk(v == 8'hFF, "R1", v, 8'hFF);

        pulse(16'd5, 8'hA5);
        rd(1'b0, 16'd5, v, oe);      chk(v == 8'hA5, "R7", v, 8'hA5);
        pulse(16'd5, 8'h3C);
        rd(1'b0, 16'd5, v, oe);      chk(v == 8'h24, "R5", v, 8'h24);
        pulse(16'd5, 8'hFF);
        rd(1'b0, 16'd5, v, oe);      chk(v == 8'h24, "R5", v, 8'h24);

        // chip enable held low: only the first edge programs
        drive(1'b1, 2'b10, 1'b0, 16'd7, 8'hF0);
        drive(1'b0, 2'b10, 1'b0, 16'd7, 8'hF0);
        drive(1'b0, 2'b10, 1'b0, 16'd7, 8'h0F);
        drive(1'b0, 2'b10, 1'b0, 16'd7, 8'h00);
        @(negedge clk); #1;
        chk(dq_oe == 1'b0, "R5", dq_oe, 0);
        rd(1'b0, 16'd7, v, oe);      chk(v == 8'hF0, "R5", v, 8'hF0);

        // inhibit: chip enable high at program level
        drive(1'b1, 2'b10, 1'b0, 16'd9, 8'h00);
        drive(1'b1, 2'b10, 1'b0, 16'd9, 8'h11);
        @(negedge clk); #1;
        chk(dq_oe == 1'b0, "R6", dq_oe, 0);
        rd(1'b0, 16'd9, v, oe);      chk(v == 8'hFF, "R6", v, 8'hFF);

        // standby and disable float
        drive(1'b1, 2'b00, 1'b0, 16'd5, 8'h00);
        @(negedge clk); #1;          chk(dq_oe == 1'b0, "R3", dq_oe, 0);
        drive(1'b0, 2'b01, 1'b0, 16'd5, 8'h00);
        @(negedge clk); #1;          chk(dq_oe == 1'b0, "R4", dq_oe, 0);
        drive(1'b0, 2'b11, 1'b0, 16'd5, 8'h00);
        @(negedge clk); #1;          chk(dq_oe == 1'b0, "R4", dq_oe, 0);

        // identifier
        rd(1'b1, 16'h0000, v, oe);   chk(v == 8'hC2 && oe, "R8", v, 8'hC2);
        chk(^v == 1'b1, "R9", ^v, 1);
        rd(1'b1, 16'h0201, v, oe);   chk(v == 8'h91, "R8", v, 8'h91);
        chk(^v == 1'b1, "R9", ^v, 1);
        rd(1'b1, 16'h0005, v, oe);   chk(v == 8'h24, "R10", v, 8'h24);

        // aliasing
        pulse(16'd1024 + 16'd12, 8'h5A);
        rd(1'b0, 16'd12, v, oe);     chk(v == 8'h5A, "R11", v, 8'h5A);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            automatic logic [15:0] al [8] = '{16'h0000, 16'h0001, 16'h0200, 16'h0201,
                                              16'h0202, 16'h8001, 16'h0005, 16'h0405};
            automatic logic [15:0] a = ($urandom % 4 == 0) ? 16'($urandom) : al[$urandom % 8];
            automatic logic [7:0]  d = ($urandom % 2) ? 8'($urandom | $urandom) : 8'hFF;
            drive(($urandom % 3) == 0, 2'($urandom), ($urandom % 2) == 0, a, d);
        end
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule